// File: doc/BRIEF.md
# Chainable serial bitstream source

This block holds a small bitstream and shifts it out one bit per rising clock edge to a device that is being configured. Two control inputs gate it. A low level on the enable-reset input (`oe`) clears the bit pointer and silences the output. Once `oe` is high again, the active-low select (`ncs`) decides whether the pointer advances and the output drives. The output is split into a value and a drive-enable flag. The enclosing design or testbench resolves one shared serial line from the flags of several units.

Several identical units form one longer stream. Each unit's `ncasc` output feeds the `ncs` input of the next unit. The first unit's `ncs` comes from the configured device's done signal. Clock, `oe` and the serial line are common to all units. When a unit has presented its final bit, it pulls `ncasc` low and releases the line, and the next unit drives it on the following cycle. A unit built with `CASCADABLE = 0` never hands over. The contents are loaded through a byte write port that works only while `oe` is low. `DEPTH_BYTES` must be a power of two and at least 2.

Top module: `cfg_stream_unit`

## Requirements
- R1: After `rst`, `data_oe` is 0 and `ncasc` is 1. Until `oe` has been sampled low at least once, `ncs` low does not start streaming.
- R2: On every clock edge where `oe` is low, the bit pointer returns to 0. `data_oe` is 0 in the following cycle, whatever the level of `ncs`.
- R3: While `oe` is high and `ncs` is high, `data_oe` is 0 in the next cycle and the pointer does not move.
- R4: On each edge where `oe` is high, `ncs` is low, the unit is armed and the stream is not finished, bit `p` is presented in the next cycle with `data_oe` = 1, and the pointer `p` increments. Bit `p` is bit `p mod 8` of stored byte `p / 8`, so each byte goes out LSB first.
- R5: Raising `ncs` mid-stream pauses it. When `ncs` falls again, the stream resumes with the next unsent bit.
- R6: In the cycle where the final bit (`p = 8*DEPTH_BYTES-1`) is on the line, `ncasc` is 0 on a cascadable unit. It stays 0 until `oe` goes low, and `data_oe` stays 0 afterwards.
- R7: With `CASCADABLE = 0`, `ncasc` remains 1 even after the final bit.
- R8: `oe` low takes priority over streaming in the same cycle. This holds even on the edge that would present the final bit: the next cycle shows `data_oe` = 0 and `ncasc` = 1, and streaming restarts from bit 0.
- R9: A byte write (`wr_en`, `wr_addr`, `wr_byte`) updates the store only when `oe` is low. A write with `oe` high leaves the contents unchanged.
- R10: In a chain, consecutive units drive the shared line in consecutive cycles, with no gap and never two drivers at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| oe | input | 1 | Enable-reset; low clears the pointer and arms the unit |
| ncs | input | 1 | Active-low select; from the previous unit's `ncasc` or the done signal |
| wr_en | input | 1 | Byte write strobe, honoured only while `oe` is low |
| wr_addr | input | $clog2(DEPTH_BYTES) | Byte index for a write |
| wr_byte | input | 8 | Byte written |
| data_val | output | 1 | Bit value presented on the serial line |
| data_oe | output | 1 | 1 when this unit drives the serial line |
| ncasc | output | 1 | Active-low hand-over to the next unit |

## Verification
Two collisions matter: the `oe` reset can fall on an edge where the pointer would advance, and the hand-over can fall on the edge where the next unit starts. The bench lowers `oe` on the very edge that would present the final bit. It expects a silent line, `ncasc` high and a restart from bit 0. For the hand-over, a three-unit chain streams across both boundaries. A behavioural per-unit model is compared with every output on every clock. The bench also counts drivers on the shared line and requires at most one, and exactly one during the stream.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  // bits held per stored byte
  localparam int BITS_PER_BYTE = 8;
  // width of the bit-within-byte select
  localparam int BIT_SEL_W = 3;
endpackage

// File: rtl/cfg_stream_store.sv
module cfg_stream_store
  import cfg_stream_pkg::*;
#(
  parameter int DEPTH_BYTES = 4,
  localparam int BYTE_AW = $clog2(DEPTH_BYTES),
  localparam int ADDR_W  = BYTE_AW + BIT_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_AW-1:0] wr_addr,
  input  logic [7:0]        wr_byte,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              bit_q
);
  logic [BITS_PER_BYTE-1:0] mem [DEPTH_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_byte;
  end

  // registered read, bit picked LSB first within the byte
  always_ff @(posedge clk) begin
    if (rst)        bit_q <= 1'b0;
    else if (rd_en) bit_q <= mem[rd_addr[ADDR_W-1:BIT_SEL_W]][rd_addr[BIT_SEL_W-1:0]];
  end
endmodule

// File: rtl/cfg_stream_seq.sv
module cfg_stream_seq
  import cfg_stream_pkg::*;
#(
  parameter int DEPTH_BYTES = 4,
  parameter bit CASCADABLE  = 1'b1,
  localparam int ADDR_W = $clog2(DEPTH_BYTES) + BIT_SEL_W,
  localparam int TOTAL_BITS = DEPTH_BYTES * BITS_PER_BYTE,
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TOTAL_BITS - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe,
  input  logic              ncs,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              data_oe,
  output logic              ncasc
);
  logic [ADDR_W-1:0] addr;
  logic armed, done, drive_q, step;

  always_comb begin
    step    = oe && armed && !ncs && !done;
    rd_en   = step;
    rd_addr = addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      armed   <= 1'b0;
      done    <= 1'b0;
      drive_q <= 1'b0;
    end else if (!oe) begin
      addr    <= '0;
      armed   <= 1'b1;
      done    <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      drive_q <= step;
      if (step) begin
        addr <= addr + 1'b1;
        if (addr == LAST) done <= 1'b1;
      end
    end
  end

  assign data_oe = drive_q;

  if (CASCADABLE) begin : g_casc
    assign ncasc = ~done;
  end else begin : g_nocasc
    assign ncasc = 1'b1;
  end

  AST_OE_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    !oe |=> (!drive_q && ncasc)); // R2
  AST_NCS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (oe && ncs) |=> (!drive_q && $stable(addr))); // R3
  AST_DRIVE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    drive_q |-> (addr == ADDR_W'($past(addr) + 1'b1))); // R4
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (done && oe) |=> !drive_q); // R6
  AST_NCASC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ncasc && oe) |=> !ncasc); // R6
endmodule

// File: rtl/cfg_stream_unit.sv
module cfg_stream_unit
  import cfg_stream_pkg::*;
#(
  parameter int DEPTH_BYTES = 4,
  parameter bit CASCADABLE  = 1'b1,
  localparam int BYTE_AW = $clog2(DEPTH_BYTES),
  localparam int ADDR_W  = BYTE_AW + BIT_SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               oe,
  input  logic               ncs,
  input  logic               wr_en,
  input  logic [BYTE_AW-1:0] wr_addr,
  input  logic [7:0]         wr_byte,
  output logic               data_val,
  output logic               data_oe,
  output logic               ncasc
);
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_go;

  assign wr_go = wr_en && !oe;

  cfg_stream_seq #(.DEPTH_BYTES(DEPTH_BYTES), .CASCADABLE(CASCADABLE)) seq_i (
    .clk(clk), .rst(rst), .oe(oe), .ncs(ncs),
    .rd_en(rd_en), .rd_addr(rd_addr), .data_oe(data_oe), .ncasc(ncasc)
  );

  cfg_stream_store #(.DEPTH_BYTES(DEPTH_BYTES)) store_i (
    .clk(clk), .rst(rst), .wr_en(wr_go), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .rd_en(rd_en), .rd_addr(rd_addr), .bit_q(data_val)
  );
endmodule

// File: tb/cfg_stream_unit_tb_top.sv
module cfg_stream_unit_tb_top;
  localparam int DB = 2;
  localparam int NB = DB * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oe = 1'b1;
  logic ncs0 = 1'b1;
  logic [2:0] wr_en = '0;
  logic [0:0] wr_addr = '0;
  logic [7:0] wr_byte = '0;
  logic [2:0] dv, doe, nc;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cfg_stream_unit #(.DEPTH_BYTES(DB), .CASCADABLE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .oe(oe), .ncs(ncs0), .wr_en(wr_en[0]), .wr_addr(wr_addr),
    .wr_byte(wr_byte), .data_val(dv[0]), .data_oe(doe[0]), .ncasc(nc[0]));
  cfg_stream_unit #(.DEPTH_BYTES(DB), .CASCADABLE(1'b1)) u1_i (
    .clk(clk), .rst(rst), .oe(oe), .ncs(nc[0]), .wr_en(wr_en[1]), .wr_addr(wr_addr),
    .wr_byte(wr_byte), .data_val(dv[1]), .data_oe(doe[1]), .ncasc(nc[1]));
  cfg_stream_unit #(.DEPTH_BYTES(DB), .CASCADABLE(1'b0)) u2_i (
    .clk(clk), .rst(rst), .oe(oe), .ncs(nc[1]), .wr_en(wr_en[2]), .wr_addr(wr_addr),
    .wr_byte(wr_byte), .data_val(dv[2]), .data_oe(doe[2]), .ncasc(nc[2]));

  // behavioural reference, one entry per unit
  int m_addr [3];
  bit m_armed [3], m_done [3], m_oe [3], m_val [3];
  bit [7:0] m_mem [3][DB];
  bit casc_ok [3] = '{1'b1, 1'b1, 1'b0};
  bit [7:0] img [3][DB] = '{'{8'hA5, 8'h3C}, '{8'h0F, 8'h81}, '{8'hF0, 8'h5A}};

  function automatic bit m_ncasc(int k);
    return casc_ok[k] ? !m_done[k] : 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int drivers();
    return int'(doe[0]) + int'(doe[1]) + int'(doe[2]);
  endfunction

  function automatic int line_val();
    for (int k = 0; k < 3; k++) if (doe[k]) return int'(dv[k]);
    return -1;
  endfunction

  always @(posedge clk) begin
    bit ncs_in [3];
    ncs_in[0] = ncs0;
    ncs_in[1] = m_ncasc(0);
    ncs_in[2] = m_ncasc(1);
    for (int k = 0; k < 3; k++) begin
      if (wr_en[k] && !oe) m_mem[k][wr_addr] = wr_byte;
      if (rst) begin
        m_addr[k] = 0; m_armed[k] = 0; m_done[k] = 0; m_oe[k] = 0;
      end else if (!oe) begin
        m_addr[k] = 0; m_armed[k] = 1; m_done[k] = 0; m_oe[k] = 0;
      end else if (m_armed[k] && !ncs_in[k] && !m_done[k]) begin
        m_oe[k] = 1;
        m_val[k] = m_mem[k][m_addr[k] / 8][m_addr[k] % 8];
        if (m_addr[k] == NB - 1) m_done[k] = 1;
        m_addr[k]++;
      end else begin
        m_oe[k] = 0;
      end
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      for (int k = 0; k < 3; k++) begin
        chk(doe[k] == m_oe[k], "R3 model data_oe", int'(doe[k]), int'(m_oe[k]));
        if (m_oe[k]) chk(dv[k] == m_val[k], "R4 model data_val", int'(dv[k]), int'(m_val[k]));
        chk(nc[k] == m_ncasc(k), "R6 model ncasc", int'(nc[k]), int'(m_ncasc(k)));
      end
      chk(drivers() <= 1, "R10 single driver", drivers(), 1);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ebit(int k, int p);
    return int'(img[k][p / 8][p % 8]);
  endfunction

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk(doe[0] == 1'b0, "R1 reset data_oe", int'(doe[0]), 0);
    chk(nc[0] == 1'b1, "R1 reset ncasc", int'(nc[0]), 1);
    ncs0 = 1'b0;
    step(3);
    chk(doe[0] == 1'b0, "R1 unarmed no stream", int'(doe[0]), 0);

    // load with oe low, ncs low all along
    oe = 1'b0;
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < DB; b++) begin
        wr_en = 3'(1 << k); wr_addr = 1'(b); wr_byte = img[k][b];
        step(1);
        chk(doe[0] == 1'b0, "R2 oe low silent", int'(doe[0]), 0);
      end
    end
    wr_en = '0;

    // write attempted with oe high must be dropped
    oe = 1'b1; ncs0 = 1'b1;
    wr_en = 3'b001; wr_addr = 1'b0; wr_byte = 8'hFF;
    step(1);
    wr_en = '0;
    step(3);
    chk(doe[0] == 1'b0, "R3 ncs high idle", int'(doe[0]), 0);

    ncs0 = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk(doe[0] && (int'(dv[0]) == ebit(0, i)), "R4 R9 stream bit", int'(dv[0]), ebit(0, i));
    end
    ncs0 = 1'b1;
    step(1);
    chk(doe[0] == 1'b0, "R5 pause", int'(doe[0]), 0);
    step(2);
    ncs0 = 1'b0;
    for (int i = 6; i < NB; i++) begin
      step(1);
      chk(doe[0] && (int'(dv[0]) == ebit(0, i)), "R5 resume bit", int'(dv[0]), ebit(0, i));
    end
    chk(nc[0] == 1'b0, "R6 ncasc on final bit", int'(nc[0]), 0);

    for (int j = 0; j < 2 * NB; j++) begin
      int exp;
      exp = (j < NB) ? ebit(1, j) : ebit(2, j - NB);
      step(1);
      chk(drivers() == 1 && line_val() == exp, "R10 chain bit", line_val(), exp);
    end
    step(1);
    chk(drivers() == 0, "R10 line released", drivers(), 0);
    chk(nc[2] == 1'b1, "R7 no hand-over", int'(nc[2]), 1);
    chk(nc[0] == 1'b0 && nc[1] == 1'b0, "R6 ncasc held", int'({nc[1], nc[0]}), 0);

    // reset in the same edge as the final bit
    oe = 1'b0;
    step(1);
    oe = 1'b1;
    for (int i = 0; i < NB - 1; i++) step(1);
    chk(doe[0] && (int'(dv[0]) == ebit(0, NB - 2)), "R8 pre-collision bit", int'(dv[0]), ebit(0, NB - 2));
    oe = 1'b0;
    step(1);
    chk(doe[0] == 1'b0 && nc[0] == 1'b1, "R8 reset wins", int'({doe[0], nc[0]}), 1);
    oe = 1'b1;
    step(1);
    chk(doe[0] && (int'(dv[0]) == ebit(0, 0)), "R8 restart at bit 0", int'(dv[0]), ebit(0, 0));
    step(2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule